// File: doc/BRIEF.md
# Automatic Status Polling Matcher

This block sits beside the command sequencer of a serial-flash controller. It repeatedly asks that sequencer to read the flash status register and compares each returned status word with a programmed pattern. Only the bits selected by a separate mask take part in the compare. The sequencer is modelled as a one-cycle start request followed later by a done strobe that carries the status word.

A run begins when the start strobe arrives while the sequencer mode input selects polling. After each read the block waits a programmable number of serial-clock ticks and then issues the next read. A match sets a sticky flag, and that flag drives an interrupt when the interrupt enable is set. A match can also stop the run, if stop-on-match is enabled. Software clears the flag with a write-one-to-clear strobe. An abort input ends the run at once.

Top module: `status_poller`

## Requirements
- R1: A run starts only when `go` pulses while `mode` equals 2 (2'b10). With any other mode value, `go` is ignored and `busy` and `seq_start` stay low.
- R2: Each status read is a `seq_start` pulse lasting exactly one cycle. The block then waits, with `busy` high, until `seq_done` arrives, and issues no further request during that wait.
- R3: A returned word matches when `((seq_status ^ pattern) & mask)` is zero. Differences in bits whose mask bit is 0 do not affect the result.
- R4: With `wide` = 0 the status is one byte: bits 15:8 of `mask` are treated as zero. With `wide` = 1 all 16 bits take part.
- R5: A match sets `match_flag`, which stays set until a cycle with `clr_wr` = 1 and `clr_data` bit 3 = 1. Other `clr_data` bits have no effect. If a set and a clear occur in the same cycle, the set wins.
- R6: `irq` is high exactly when `match_flag` and `irq_en` are both high.
- R7: `abort` returns the block to idle on the next edge (`busy` and `seq_start` low). It leaves `match_flag` unchanged, and a `seq_done` in the same cycle is discarded.
- R8: With `stop_on_match` = 1, the first match ends the run: `busy` falls and no further request is made.
- R9: With `stop_on_match` = 0, a match sets the flag and polling continues with the next read.
- R10: After a non-matching or continuing read, the next `seq_start` comes after `gap` cycles in which `sck_tick` is high. With `gap` = 0 it comes immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe for a polling run |
| mode | input | 2 | Sequencer functional mode; value 2 selects polling |
| abort | input | 1 | Stops polling immediately |
| mask | input | 16 | Compare mask; bits set to 1 take part |
| pattern | input | 16 | Expected status value |
| wide | input | 1 | 1: two-byte status, 0: one-byte status |
| gap | input | 16 | Serial-clock ticks between reads |
| stop_on_match | input | 1 | End the run at the first match |
| irq_en | input | 1 | Match interrupt enable |
| clr_wr | input | 1 | Flag-clear write strobe |
| clr_data | input | 8 | Flag-clear data; bit 3 clears the match flag |
| sck_tick | input | 1 | One pulse per serial clock cycle |
| seq_start | output | 1 | Status-read request to the sequencer |
| seq_done | input | 1 | Sequencer finished a read |
| seq_status | input | 16 | Status word returned with `seq_done` |
| busy | output | 1 | Polling run in progress |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |

## Verification
The compare is tried with the following status words:
- A word that differs from the pattern only in masked-out bits. This separates a correct masked compare from a full-word compare.
- A word that differs inside the masked field. This shows a mismatch is not reported as a hit.
- A word that differs only in the upper byte, applied with `wide` set and then with it clear. This tells one-byte operation from two-byte operation.

Each hit is repeated with stop-on-match set and with it clear. This separates a halted run from a continuing one.

The interval is checked by counting ticks one at a time. It is checked with idle cycles that carry no tick, and with a zero gap. This distinguishes tick counting from cycle counting, and exposes an off-by-one count.

Abort is applied during the gap and together with a matching done strobe. This shows that abort has priority and that the flag is left alone.

// File: rtl/status_poller.sv
module status_poller #(
  parameter int          STAT_W    = 16,
  parameter int          GAP_W     = 16,
  parameter int          CLR_W     = 8,
  parameter int          CLR_BIT   = 3,
  parameter logic [1:0]  POLL_MODE = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        mode,
  input  logic              abort,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] pattern,
  input  logic              wide,
  input  logic [GAP_W-1:0]  gap,
  input  logic              stop_on_match,
  input  logic              irq_en,
  input  logic              clr_wr,
  input  logic [CLR_W-1:0]  clr_data,
  input  logic              sck_tick,
  output logic              seq_start,
  input  logic              seq_done,
  input  logic [STAT_W-1:0] seq_status,
  output logic              busy,
  output logic              match_flag,
  output logic              irq
);
  localparam int LO_W = STAT_W / 2;
  localparam int HI_W = STAT_W - LO_W;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_GAP} st_t;

  st_t              st;
  logic [GAP_W-1:0] cnt;
  logic [STAT_W-1:0] eff_mask;
  logic             hit, got, set_flag, clr_flag;

  assign eff_mask  = wide ? mask : {{HI_W{1'b0}}, mask[LO_W-1:0]};
  assign hit       = ((seq_status ^ pattern) & eff_mask) == '0;
  assign got       = (st == S_WAIT) && seq_done && !abort;
  assign set_flag  = got && hit;
  assign clr_flag  = clr_wr && clr_data[CLR_BIT];

  assign seq_start = (st == S_ISSUE);
  assign busy      = (st != S_IDLE);
  assign irq       = match_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      match_flag <= 1'b0;
    end else begin
      match_flag <= set_flag | (match_flag & ~clr_flag);
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE:  if (go && mode == POLL_MODE) st <= S_ISSUE;
          S_ISSUE: st <= S_WAIT;
          S_WAIT:
            if (seq_done) begin
              if (hit && stop_on_match) st <= S_IDLE;
              else if (gap == '0)       st <= S_ISSUE;
              else begin
                st  <= S_GAP;
                cnt <= gap;
              end
            end
          S_GAP:
            if (sck_tick) begin
              if (cnt == GAP_W'(1)) st <= S_ISSUE;
              cnt <= cnt - 1'b1;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/status_poller_chk.sv
module status_poller_chk #(
  parameter int         CLR_W     = 8,
  parameter int         CLR_BIT   = 3,
  parameter logic [1:0] POLL_MODE = 2'd2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic [1:0]       mode,
  input logic             abort,
  input logic             irq_en,
  input logic             clr_wr,
  input logic [CLR_W-1:0] clr_data,
  input logic             seq_start,
  input logic             busy,
  input logic             match_flag,
  input logic             irq
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(go && mode == POLL_MODE)) |=> (!busy && !seq_start));

  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !seq_start));

  p_abort_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !(clr_wr && clr_data[CLR_BIT])) |=> (match_flag == $past(match_flag)));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !(clr_wr && clr_data[CLR_BIT])) |=> match_flag);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind status_poller status_poller_chk #(
  .CLR_W(CLR_W), .CLR_BIT(CLR_BIT), .POLL_MODE(POLL_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .abort(abort),
  .irq_en(irq_en), .clr_wr(clr_wr), .clr_data(clr_data),
  .seq_start(seq_start), .busy(busy), .match_flag(match_flag), .irq(irq)
);

// File: tb/tb_status_poller.sv
module tb_status_poller;
  logic clk = 0, rst_n = 0;
  logic go = 0, abort = 0, wide = 1, stop_on_match = 0, irq_en = 0;
  logic clr_wr = 0, sck_tick = 0, seq_done = 0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] mask = 16'hFFFF, pattern = 16'h0, gap = 16'h0, seq_status = 16'h0;
  logic [7:0]  clr_data = 8'h0;
  logic seq_start, busy, match_flag, irq;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  status_poller dut (.*);

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poll_start();
    mode = 2'd2; go = 1; cyc(); go = 0;
  endtask

  task automatic reply(input logic [15:0] s);
    cyc(); seq_done = 1; seq_status = s; cyc(); seq_done = 0;
  endtask

  task automatic stop_all();
    abort = 1; cyc(); abort = 0;
  endtask

  task automatic clr_pulse(input logic [7:0] d);
    clr_wr = 1; clr_data = d; cyc(); clr_wr = 0; clr_data = 8'h0;
  endtask

  task automatic tick();
    sck_tick = 1; cyc(); sck_tick = 0;
  endtask

  task automatic t_reset();
    chk("reset busy", busy, 0);
    chk("reset flag", match_flag, 0);
    chk("reset irq", irq, 0);
    chk("reset start", seq_start, 0);
  endtask

  task automatic t_mode_r1();
    mode = 2'd1; go = 1; cyc(); go = 0; cyc();
    chk("R1 wrong mode busy", busy, 0);
    chk("R1 wrong mode start", seq_start, 0);
    poll_start();
    chk("R1 poll mode start", seq_start, 1);
    stop_all();
  endtask

  task automatic t_handshake_r2();
    mask = 16'hFFFF; pattern = 16'h1234;
    poll_start();
    chk("R2 request", seq_start, 1);
    cyc();
    chk("R2 one-cycle pulse", seq_start, 0);
    chk("R2 busy waiting", busy, 1);
    cyc(); cyc();
    chk("R2 no request while waiting", seq_start, 0);
    reply(16'h0000);
    chk("R2 mismatch no flag", match_flag, 0);
    stop_all();
  endtask

  task automatic t_mask_r3();
    wide = 1; mask = 16'h00F0; pattern = 16'h0050; gap = 0; stop_on_match = 0;
    poll_start();
    reply(16'h0060);
    chk("R3 masked field differs", match_flag, 0);
    chk("R10 gap zero immediate", seq_start, 1);
    reply(16'hAB5C);
    chk("R3 differs only outside mask", match_flag, 1);
    stop_all(); clr_pulse(8'h08);
  endtask

  task automatic t_width_r4();
    mask = 16'hFF01; pattern = 16'h0001; wide = 1;
    poll_start(); reply(16'h3301);
    chk("R4 wide upper byte compared", match_flag, 0);
    stop_all();
    wide = 0;
    poll_start(); reply(16'h3301);
    chk("R4 narrow upper mask ignored", match_flag, 1);
    stop_all();
    wide = 1;
  endtask

  task automatic t_clear_r5_r6();
    irq_en = 1; cyc();
    chk("R6 irq with flag", irq, 1);
    clr_pulse(8'h07);
    chk("R5 other clear bits ignored", match_flag, 1);
    irq_en = 0; cyc();
    chk("R6 irq masked", irq, 0);
    irq_en = 1;
    clr_pulse(8'h08);
    chk("R5 bit3 clears flag", match_flag, 0);
    chk("R6 irq follows flag", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_stop_r8();
    mask = 16'hFFFF; pattern = 16'hA5A5; stop_on_match = 1; gap = 0;
    poll_start(); reply(16'hA5A5);
    chk("R8 flag on match", match_flag, 1);
    chk("R8 run ended", busy, 0);
    cyc(); cyc(); cyc();
    chk("R8 no further request", seq_start, 0);
    stop_on_match = 0;
  endtask

  task automatic t_continue_r9();
    clr_pulse(8'h08);
    poll_start(); reply(16'hA5A5);
    chk("R9 flag set", match_flag, 1);
    chk("R9 next request issued", seq_start, 1);
    reply(16'h0000);
    chk("R5 flag sticky after miss", match_flag, 1);
    chk("R9 still busy", busy, 1);
    stop_all(); clr_pulse(8'h08);
  endtask

  task automatic t_gap_r10();
    gap = 16'd3; pattern = 16'h1111;
    poll_start(); reply(16'h0000);
    chk("R10 no request right after read", seq_start, 0);
    chk("R10 busy in gap", busy, 1);
    cyc(); cyc();
    chk("R10 idle cycles do not count", seq_start, 0);
    tick(); tick();
    chk("R10 two of three ticks", seq_start, 0);
    tick();
    chk("R10 request after third tick", seq_start, 1);
    stop_all();
  endtask

  task automatic t_abort_r7();
    pattern = 16'h2222; gap = 16'd3;
    poll_start(); reply(16'h2222);
    chk("R7 setup flag", match_flag, 1);
    stop_all();
    chk("R7 idle after abort", busy, 0);
    chk("R7 flag kept", match_flag, 1);
    clr_pulse(8'h08);
    poll_start(); cyc();
    seq_done = 1; seq_status = 16'h2222; abort = 1; cyc();
    seq_done = 0; abort = 0;
    chk("R7 done with abort discarded", match_flag, 0);
    chk("R7 abort wins", busy, 0);
    cyc();
    chk("R7 no request after abort", seq_start, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    t_reset();
    t_mode_r1();
    t_handshake_r2();
    t_mask_r3();
    t_width_r4();
    t_clear_r5_r6();
    t_stop_r8();
    t_continue_r9();
    t_gap_r10();
    t_abort_r7();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule